// File: doc/BRIEF.md
# Buffered Host Port for Display Data RAM

This block is the parallel microprocessor port of a display controller that keeps its own 256-byte display data RAM. A host reaches it through two chip-select lines, one of each polarity, a command/data flag, active-low read and write strobes, and an 8-bit data bus. The bus is split into an input path, an output path and an output-enable that the pad ring uses to drive or release the pins.

One holding register sits between the host and the RAM. A data write places the byte in that register and stores it in the RAM at the address pointer in the same access. A data read hands the host whatever the register already holds, and on the strobe's release loads it with the RAM byte at the pointer. A read therefore always returns the byte fetched by the previous read. After an address load or a data write, the host must issue one dummy read before it sees valid RAM contents. A write with the command/data flag low loads the address pointer. The pointer advances by one after each data access and wraps from 255 to 0.

The strobes arrive asynchronously. They are synchronised to the block clock and act on their rising (release) edge. A strobe held low for any length of time produces exactly one access.

Top module: `dispram_host_port`

## Requirements
- R1: The port is selected only while `sel_lo_n` is 0 and `sel_hi` is 1. With any other combination, read and write strobes change neither the RAM, the holding register nor the address pointer.
- R2: `bus_oe` is 1 only while the port is selected, `dc_sel` is 1, `rd_n` is 0 and reset is released. It is 0 at all other times.
- R3: An active-low `rst_n` clears the holding register and the address pointer to 0 and forces `bus_oe` to 0, whatever the chip-select lines are doing.
- R4: A selected write with `dc_sel` = 0 loads the address pointer with `bus_in` and leaves the holding register unchanged.
- R5: A selected write with `dc_sel` = 1 stores `bus_in` into the RAM at the pointer, copies it into the holding register and advances the pointer by one.
- R6: During a selected read with `dc_sel` = 1, `bus_out` shows the holding register. On the strobe's release, the register takes the RAM byte at the pointer and the pointer advances by one.
- R7: The first data read after an address load returns the old holding-register contents. The second returns the RAM byte at the loaded address, and later reads return the following addresses in order.
- R8: The first data read after a data write returns the byte just written, not the RAM byte at the advanced pointer.
- R9: The address pointer wraps from 255 to 0 on both data writes and data reads.
- R10: A selected read with `dc_sel` = 0 keeps `bus_oe` at 0 and changes neither the pointer nor the holding register.
- R11: Each strobe produces exactly one access on its rising edge, however long it is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_lo_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| dc_sel | input | 1 | 0 = command (address load), 1 = display data |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_in | input | 8 | Data bus from the host |
| bus_out | output | 8 | Data bus to the host (holding register) |
| bus_oe | output | 1 | Drive enable for the data bus pins |

## Verification
The embedded assertions check on every cycle the rules that relate one cycle to the next:
- A deselected port leaves the pointer and holding register unchanged.
- An address load sets the pointer from the bus and leaves the register alone.
- A data write captures the bus byte and advances the pointer.
- A data read moves the RAM byte into the register.
- The synchroniser emits single-cycle release pulses.

The one-read delay only shows in the bench's scenarios, as do the wrap of the full RAM, the dummy read after an address load or a write, and the single access from a long strobe. Each of these needs a sequence of host transactions compared against a reference model of the RAM and pointer.

// File: rtl/dhp_pkg.sv
package dhp_pkg;

    localparam int DHP_DATA_W = 8;
    localparam int DHP_ADDR_W = 8;

    // Kind of host access decoded on a strobe release.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_CMD  = 2'd1,
        ACC_WR   = 2'd2,
        ACC_RD   = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/dhp_strobe_sync.sv
module dhp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic release_p
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              last_d, last_q;

    always_comb begin
        sync_d    = {sync_q[STAGES-2:0], strobe_n};
        last_d    = sync_q[STAGES-1];
        release_p = sync_q[STAGES-1] & ~last_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    // R11: a release yields one pulse, never two in a row
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        release_p |=> !release_p);

endmodule

// File: rtl/dhp_access_decode.sv
module dhp_access_decode
    import dhp_pkg::*;
(
    input  logic      sel_lo_n,
    input  logic      sel_hi,
    input  logic      dc_sel,
    input  logic      rd_rel,
    input  logic      wr_rel,
    output acc_kind_e kind
);
    logic selected;

    always_comb begin
        selected = ~sel_lo_n & sel_hi;
        kind     = ACC_NONE;
        if (selected) begin
            if (wr_rel)
                kind = dc_sel ? ACC_WR : ACC_CMD;
            else if (rd_rel && dc_sel)
                kind = ACC_RD;
        end
    end

endmodule

// File: rtl/dhp_ram.sv
module dhp_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/dispram_host_port.sv
module dispram_host_port
    import dhp_pkg::*;
#(
    parameter int DATA_W      = DHP_DATA_W,
    parameter int ADDR_W      = DHP_ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              dc_sel,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] hold;
    } port_state_t;

    port_state_t       st_d, st_q;
    logic              rd_rel, wr_rel;
    acc_kind_e         kind;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;

    dhp_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_n  (rd_n),
        .release_p (rd_rel)
    );

    dhp_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_n  (wr_n),
        .release_p (wr_rel)
    );

    dhp_access_decode u_decode (
        .sel_lo_n (sel_lo_n),
        .sel_hi   (sel_hi),
        .dc_sel   (dc_sel),
        .rd_rel   (rd_rel),
        .wr_rel   (wr_rel),
        .kind     (kind)
    );

    dhp_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (st_q.ptr),
        .wdata (bus_in),
        .rdata (ram_rdata)
    );

    always_comb begin
        st_d   = st_q;
        ram_we = 1'b0;
        unique case (kind)
            ACC_CMD: st_d.ptr = ADDR_W'(bus_in);
            ACC_WR: begin
                ram_we    = 1'b1;
                st_d.hold = bus_in;
                st_d.ptr  = st_q.ptr + 1'b1;
            end
            ACC_RD: begin
                st_d.hold = ram_rdata;
                st_d.ptr  = st_q.ptr + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bus_out = st_q.hold;
    assign bus_oe  = rst_n & ~sel_lo_n & sel_hi & dc_sel & ~rd_n;

    // R1: no state change while the chip selects are inactive
    a_r1_desel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lo_n || !sel_hi) |=> $stable(st_q));

    // R4: an address load takes the bus byte and keeps the holding register
    a_r4_cmd_load: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_CMD) |=> (st_q.ptr == ADDR_W'($past(bus_in))) && $stable(st_q.hold));

    // R5: a data write captures the bus byte and advances the pointer
    a_r5_wr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WR) |=> (st_q.hold == $past(bus_in))
                             && (st_q.ptr == ADDR_W'($past(st_q.ptr) + 1'b1)));

    // R6: a data read moves the RAM byte into the holding register
    a_r6_rd_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_RD) |=> (st_q.hold == $past(ram_rdata)));

    // R10: a command-side read leaves the state alone
    a_r10_cmd_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rel && !wr_rel && !dc_sel) |=> $stable(st_q));

endmodule

// File: tb/dispram_host_port_bench.sv
module dispram_host_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_lo_n = 1'b1;
    logic       sel_hi = 1'b0;
    logic       dc_sel = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;

    always #2 clk = ~clk;

    dispram_host_port u_dispram_host_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_lo_n (sel_lo_n),
        .sel_hi   (sel_hi),
        .dc_sel   (dc_sel),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe)
    );

    typedef struct {
        logic       oe;
        logic       chk_data;
        logic [7:0] data;
        string      req;
    } exp_t;

    exp_t expq[$];
    event sample_ev;
    int   checks = 0;
    int   fails  = 0;

    // Reference model
    logic [7:0] m_ram [256];
    logic [7:0] m_ptr  = 8'h00;
    logic [7:0] m_hold = 8'h00;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares with the port
    initial begin
        forever begin
            @(sample_ev);
            if (expq.size() != 0) begin
                exp_t e;
                e = expq.pop_front();
                check(bus_oe === e.oe, {e.req, " oe"}, 32'(bus_oe), 32'(e.oe));
                if (e.chk_data)
                    check(bus_out === e.data, {e.req, " data"}, 32'(bus_out), 32'(e.data));
            end
        end
    end

    task automatic host_write(input bit a0, input bit s_lo_n, input bit s_hi,
                              input logic [7:0] d, input int low_cyc);
        @(negedge clk);
        sel_lo_n = s_lo_n; sel_hi = s_hi; dc_sel = a0; bus_in = d;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (low_cyc) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        if (!s_lo_n && s_hi) begin
            if (a0) begin
                m_ram[m_ptr] = d;
                m_hold = d;
                m_ptr = m_ptr + 8'd1;
            end else begin
                m_ptr = d;
            end
        end
        sel_lo_n = 1'b1; sel_hi = 1'b0;
    endtask

    task automatic host_read(input bit a0, input bit s_lo_n, input bit s_hi,
                             input string req, input int low_cyc);
        exp_t e;
        bit   sel;
        sel = !s_lo_n && s_hi;
        @(negedge clk);
        sel_lo_n = s_lo_n; sel_hi = s_hi; dc_sel = a0;
        @(negedge clk);
        rd_n = 1'b0;
        repeat (low_cyc) @(negedge clk);
        e.oe = sel && a0;
        e.chk_data = sel && a0;
        e.data = m_hold;
        e.req = req;
        expq.push_back(e);
        ->sample_ev;
        @(negedge clk);
        rd_n = 1'b1;
        repeat (6) @(negedge clk);
        if (sel && a0) begin
            m_hold = m_ram[m_ptr];
            m_ptr = m_ptr + 8'd1;
        end
        sel_lo_n = 1'b1; sel_hi = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R3: reset state, read strobe low while selected
        sel_lo_n = 1'b0; sel_hi = 1'b1; dc_sel = 1'b1; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_oe === 1'b0, "R3 oe in reset", 32'(bus_oe), 0);
        check(bus_out === 8'h00, "R3 hold in reset", 32'(bus_out), 0);
        rd_n = 1'b1; sel_lo_n = 1'b1; sel_hi = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(bus_oe === 1'b0, "R2 oe idle", 32'(bus_oe), 0);

        // R4 address load, R5 fill the whole RAM, R9 write wrap back to 0
        host_write(1'b0, 1'b0, 1'b1, 8'h00, 2);
        for (int i = 0; i < 256; i++)
            host_write(1'b1, 1'b0, 1'b1, 8'((i * 7 + 3) ^ 8'h5A), 2);

        // R8: first read after a write returns the written byte
        host_read(1'b1, 1'b0, 1'b1, "R8 read after write", 2);
        // R6: streaming reads, one behind the fetch (R9 pointer wrapped to 0)
        for (int i = 0; i < 5; i++)
            host_read(1'b1, 1'b0, 1'b1, "R6 streaming read", 2);

        // R7: dummy read after an address load
        host_write(1'b0, 1'b0, 1'b1, 8'h40, 2);
        host_read(1'b1, 1'b0, 1'b1, "R7 dummy read", 2);
        host_read(1'b1, 1'b0, 1'b1, "R7 first valid", 2);
        host_read(1'b1, 1'b0, 1'b1, "R7 next address", 2);

        // R1: deselected writes in all three inactive combinations
        host_write(1'b0, 1'b1, 1'b1, 8'h80, 2);
        host_write(1'b1, 1'b1, 1'b0, 8'hEE, 2);
        host_write(1'b1, 1'b0, 1'b0, 8'hDD, 2);
        host_write(1'b1, 1'b1, 1'b1, 8'hCC, 2);
        // R1 / R2: deselected reads drive nothing and change nothing
        host_read(1'b1, 1'b1, 1'b1, "R1 desel read", 2);
        host_read(1'b1, 1'b0, 1'b0, "R2 desel read", 2);
        // R1: pointer and RAM still intact
        host_read(1'b1, 1'b0, 1'b1, "R1 pointer unchanged", 2);
        host_read(1'b1, 1'b0, 1'b1, "R1 ram unchanged", 2);

        // R10: command-side read has no effect and no drive
        host_read(1'b0, 1'b0, 1'b1, "R10 cmd read", 2);
        host_read(1'b1, 1'b0, 1'b1, "R10 state kept", 2);

        // R11: long strobes act once
        host_read(1'b1, 1'b0, 1'b1, "R11 long read", 25);
        host_read(1'b1, 1'b0, 1'b1, "R11 after long read", 2);
        host_write(1'b0, 1'b0, 1'b1, 8'h90, 2);
        host_write(1'b1, 1'b0, 1'b1, 8'hA5, 30);
        host_write(1'b1, 1'b0, 1'b1, 8'h3C, 2);
        host_write(1'b0, 1'b0, 1'b1, 8'h90, 2);
        host_read(1'b1, 1'b0, 1'b1, "R11 dummy", 2);
        host_read(1'b1, 1'b0, 1'b1, "R11 single write", 2);
        host_read(1'b1, 1'b0, 1'b1, "R11 next write", 2);

        // R9: read wrap from 255 to 0
        host_write(1'b0, 1'b0, 1'b1, 8'hFE, 2);
        host_read(1'b1, 1'b0, 1'b1, "R9 dummy", 2);
        host_read(1'b1, 1'b0, 1'b1, "R9 addr FE", 2);
        host_read(1'b1, 1'b0, 1'b1, "R9 addr FF", 2);
        host_read(1'b1, 1'b0, 1'b1, "R9 addr 00", 2);

        // R3: reset while deselected clears pointer and holding register
        @(negedge clk);
        sel_lo_n = 1'b1; sel_hi = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_ptr = 8'h00; m_hold = 8'h00;
        repeat (3) @(negedge clk);
        host_read(1'b1, 1'b0, 1'b1, "R3 cleared hold", 2);
        host_read(1'b1, 1'b0, 1'b1, "R3 pointer zero", 2);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule